// File: doc/BRIEF.md
# EDO DRAM Byte-Lane Output Control

This block is the device-side control of an extended-data-out DRAM, modelled synchronously. It samples the row strobe, the two byte-column strobes, write enable and output enable on a fast system clock. From the two byte strobes it forms one internal column strobe. It then classifies every access as a read, an early write, a late write or a refresh, and from that produces an output enable for each 8-bit lane, the latched read word, and a write pulse for each lane. A small array backs the block, so that written data can be read back through the normal pins.

Read data stays on the pins after the column strobe returns high, as long as the row stays open, output enable stays low and no write begins. Output enable and write enable can each switch the lanes off during the column-high time. Once switched off this way, the lanes stay off until the next column-strobe fall. Every strobe is active low. All inputs pass through two-flop synchronizers, and each minimum pulse width is counted in clock samples.

Top module: `edo_lane_ctrl`

## Requirements
- R1: The internal column strobe is active while either byte strobe is low. Output-enable pulses cannot switch the lanes off while one byte strobe is still low.
- R2: `casl_ni` (low) selects lane 0, bits 7:0. `cash_ni` (low) selects lane 1, bits 15:8. A lane whose strobe stays high is neither driven nor written, and its stored byte is kept.
- R3: When a byte strobe falls with the row open and `we_ni` high, that lane loads the stored byte at {row, column}. The lane is then driven while `oe_ni` is low.
- R4: After the column strobes rise, the read lanes keep driving the latched data while the row stays open, `oe_ni` stays low and no write enable falls.
- R5: If `oe_ni` is high when the internal column strobe rises and stays high for OEHC_MIN samples, the lanes switch off. They stay off, whatever `oe_ni` does, until a byte strobe falls again. A shorter high time does not switch them off.
- R6: If `oe_ni` is low at the column rise and then pulses high for at least OEP_MIN samples during the column-high time, the lanes switch off and stay off until the next strobe fall. A shorter pulse leaves them driving.
- R7: A fall of `we_ni` switches all lanes off, except during a late write with `oe_ni` low. They stay off until a byte strobe falls with `we_ni` high.
- R8: Once the row strobe and both byte strobes are high, all lanes stop driving. After reset no lane drives and no write or refresh pulse is active.
- R9: Early write: if a byte strobe falls while `we_ni` is low, that lane is written with `dq_i` and does not drive for the rest of the access, even with `oe_ni` low.
- R10: Late write: if `we_ni` falls during a read with `oe_ni` high, the read lanes are written with the `dq_i` present at that fall. With `oe_ni` low there is no write, and the lanes keep driving the read data.
- R11: If the row strobe falls while a byte strobe is low, the cycle is a refresh. It gives a one-cycle `cbr_stb_o` and sets `ref_row_o` to an internal counter that starts at 0 and steps by one for each such refresh. A refresh cycle makes no write and drives no lane. A row-strobe fall with both byte strobes high gives neither.
- R12: Every write shows a one-cycle `wr_stb_o` with one bit per written lane. `wr_addr_o` is {row, column}, with the row in the upper ADDR_W bits, and `wr_data_o` is the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| casl_ni | input | 1 | Lower-lane column strobe, active low |
| cash_ni | input | 1 | Upper-lane column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the pins |
| dq_o | output | 16 | Latched read data |
| dq_oe_o | output | 2 | Per-lane drive enable |
| wr_stb_o | output | 2 | Per-lane write pulse |
| wr_addr_o | output | 2*ADDR_W | Write address {row, column} |
| wr_data_o | output | 16 | Write data |
| cbr_stb_o | output | 1 | Strobe-before-row refresh pulse |
| ref_row_o | output | ADDR_W | Row chosen by the refresh counter |

## Verification
The interesting collision is a write-enable fall that lands in the same synchronized sample as the column-strobe fall. That one sample then holds both a possible late-write trigger and an access start. The bench provokes it by changing `we_ni` and both byte strobes in the same step, so that both cross the synchronizers together. The result is judged correct when exactly one write pulse appears with the new data, no lane drives, and a later read returns that word. A late write with output enable still low is the second overlap, and it is judged by the absence of a write pulse while the read data stays on the pins.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DQ_W   = LANES * LANE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_CBR} row_st_e;
endpackage

// File: rtl/edo_sync.sv
module edo_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/edo_cas_merge.sv
module edo_cas_merge #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_n_i,
  output logic [LANES-1:0] lane_low_o,
  output logic [LANES-1:0] lane_fall_o,
  output logic             cas_act_o,
  output logic             cas_rise_o
);
  logic [LANES-1:0] lane_low_q;

  assign lane_low_o = ~lane_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lane_low_q <= '0;
    else         lane_low_q <= lane_low_o;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_edge
    assign lane_fall_o[g] = lane_low_o[g] & ~lane_low_q[g];
  end

  // first fall opens, last rise closes
  assign cas_act_o  = |lane_low_o;
  assign cas_rise_o = ~cas_act_o & (|lane_low_q);
endmodule

// File: rtl/edo_oe_guard.sv
module edo_oe_guard #(
  parameter int OEHC_MIN = 4,
  parameter int OEP_MIN  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cas_act_i,
  input  logic cas_rise_i,
  input  logic oe_high_i,
  output logic kill_o
);
  localparam int MAXT = (OEHC_MIN > OEP_MIN) ? OEHC_MIN : OEP_MIN;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt_q, thr, thr_m1;
  logic          hc_q, hc_sel, counting;

  // hold threshold applies when OE was already high at the column rise
  assign hc_sel   = cas_rise_i ? oe_high_i : hc_q;
  assign thr      = hc_sel ? CW'(OEHC_MIN) : CW'(OEP_MIN);
  assign thr_m1   = thr - CW'(1);
  assign counting = oe_high_i & ~cas_act_i;
  assign kill_o   = counting & (cnt_q == thr_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hc_q  <= 1'b0;
    end else begin
      if (!counting)        cnt_q <= '0;
      else if (cnt_q != thr) cnt_q <= cnt_q + CW'(1);
      hc_q <= oe_high_i ? hc_sel : 1'b0;
    end
  end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int OEHC_MIN = 4,
  parameter int OEP_MIN  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ras_ni,
  input  logic                  casl_ni,
  input  logic                  cash_ni,
  input  logic                  we_ni,
  input  logic                  oe_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DQ_W-1:0]       dq_i,
  output logic [DQ_W-1:0]       dq_o,
  output logic [LANES-1:0]      dq_oe_o,
  output logic [LANES-1:0]      wr_stb_o,
  output logic [2*ADDR_W-1:0]   wr_addr_o,
  output logic [DQ_W-1:0]       wr_data_o,
  output logic                  cbr_stb_o,
  output logic [ADDR_W-1:0]     ref_row_o
);
  localparam int MEM_AW = 2 * ADDR_W;
  localparam int DEPTH  = 1 << MEM_AW;

  logic [4:0]             ctrl_s;
  logic                   ras_s, cash_s, casl_s, we_s, oe_s;
  logic [ADDR_W+DQ_W-1:0] data_s;
  logic [ADDR_W-1:0]      col_in;
  logic [DQ_W-1:0]        dq_in;

  edo_sync #(.W(5), .RST_VAL(5'b11111)) u_sync_ctrl (
    .clk_i, .rst_ni,
    .d_i({ras_ni, cash_ni, casl_ni, we_ni, oe_ni}),
    .q_o(ctrl_s)
  );
  edo_sync #(.W(ADDR_W + DQ_W), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni,
    .d_i({addr_i, dq_i}),
    .q_o(data_s)
  );
  assign {ras_s, cash_s, casl_s, we_s, oe_s} = ctrl_s;
  assign {col_in, dq_in} = data_s;

  logic [LANES-1:0] lane_low, lane_fall;
  logic             cas_act, cas_rise, oe_kill;

  edo_cas_merge #(.LANES(LANES)) u_cas (
    .clk_i, .rst_ni,
    .lane_n_i({cash_s, casl_s}),
    .lane_low_o(lane_low),
    .lane_fall_o(lane_fall),
    .cas_act_o(cas_act),
    .cas_rise_o(cas_rise)
  );

  edo_oe_guard #(.OEHC_MIN(OEHC_MIN), .OEP_MIN(OEP_MIN)) u_oe (
    .clk_i, .rst_ni,
    .cas_act_i(cas_act),
    .cas_rise_i(cas_rise),
    .oe_high_i(oe_s),
    .kill_o(oe_kill)
  );

  row_st_e           st_q;
  logic [ADDR_W-1:0] row_q, col_q, ref_cnt_q, ref_row_q;
  logic              ras_act, ras_act_q, we_low, we_low_q, cbr_q;
  logic [LANES-1:0]  rd_valid_q, lane_rd_q, wr_stb_q;
  logic [DQ_W-1:0]   out_q, wr_data_q, rd_word;
  logic [MEM_AW-1:0] wr_addr_q, wr_addr_c;
  logic [DQ_W-1:0]   mem_q [DEPTH];

  logic             in_row, ras_fall, ras_rise, we_fall, late_ok, we_kill, idle;
  logic [LANES-1:0] rd_lane_c, ew_lane_c, lw_lane_c, wr_en_c;

  assign ras_act  = ~ras_s;
  assign we_low   = ~we_s;
  assign ras_fall = ras_act & ~ras_act_q;
  assign ras_rise = ~ras_act & ras_act_q;
  assign we_fall  = we_low & ~we_low_q;
  assign in_row   = (st_q == ST_ROW);
  assign idle     = ~ras_act & ~cas_act;
  // late write needs OE high; with OE low the read is kept
  assign late_ok  = we_fall & in_row & cas_act & oe_s;
  assign we_kill  = we_fall & ~(in_row & cas_act & ~oe_s);

  assign rd_lane_c = lane_fall & {LANES{in_row & ~we_low}};
  assign ew_lane_c = lane_fall & {LANES{in_row & we_low}};
  assign lw_lane_c = lane_low & lane_rd_q & {LANES{late_ok}};
  assign wr_en_c   = ew_lane_c | lw_lane_c;
  assign wr_addr_c = {row_q, (|ew_lane_c) ? col_in : col_q};
  assign rd_word   = mem_q[{row_q, col_in}];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en_c[l]) mem_q[wr_addr_c][l*LANE_W +: LANE_W] <= dq_in[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      ref_cnt_q  <= '0;
      ref_row_q  <= '0;
      cbr_q      <= 1'b0;
      ras_act_q  <= 1'b0;
      we_low_q   <= 1'b0;
      rd_valid_q <= '0;
      lane_rd_q  <= '0;
      out_q      <= '0;
      wr_stb_q   <= '0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      ras_act_q <= ras_act;
      we_low_q  <= we_low;
      cbr_q     <= 1'b0;
      wr_stb_q  <= wr_en_c;
      wr_addr_q <= wr_addr_c;
      wr_data_q <= dq_in;

      if (ras_fall) begin
        if (cas_act) begin
          st_q      <= ST_CBR;
          cbr_q     <= 1'b1;
          ref_row_q <= ref_cnt_q;
          ref_cnt_q <= ref_cnt_q + ADDR_W'(1);
        end else begin
          st_q  <= ST_ROW;
          row_q <= col_in;
        end
      end else if (ras_rise) begin
        st_q <= ST_IDLE;
      end

      if (|(lane_fall) && in_row) col_q <= col_in;

      for (int l = 0; l < LANES; l++) begin
        if (rd_lane_c[l]) begin
          out_q[l*LANE_W +: LANE_W] <= rd_word[l*LANE_W +: LANE_W];
          rd_valid_q[l] <= 1'b1;
          lane_rd_q[l]  <= 1'b1;
        end else if (ew_lane_c[l] || lw_lane_c[l]) begin
          rd_valid_q[l] <= 1'b0;
          lane_rd_q[l]  <= 1'b0;
        end
      end

      // sticky off conditions; none coincides with a read fall
      if (we_kill || oe_kill || idle) rd_valid_q <= '0;
      if (idle) lane_rd_q <= '0;
    end
  end

  assign dq_o      = out_q;
  assign dq_oe_o   = rd_valid_q & {LANES{~oe_s}};
  assign wr_stb_o  = wr_stb_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign cbr_stb_o = cbr_q;
  assign ref_row_o = ref_row_q;
endmodule

// File: rtl/edo_lane_ctrl_chk.sv
module edo_lane_ctrl_chk
  import edo_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_act_i,
  input logic             cas_act_i,
  input logic [LANES-1:0] lane_low_i,
  input logic [LANES-1:0] lane_fall_i,
  input logic [LANES-1:0] rd_valid_i,
  input logic [LANES-1:0] dq_oe_i,
  input logic [LANES-1:0] wr_stb_i,
  input logic             cbr_stb_i
);
  AST_CBR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_stb_i |-> (wr_stb_i == '0)); // R11

  AST_CBR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_stb_i |=> !cbr_stb_i); // R11

  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_act_i && !cas_act_i) |=> (dq_oe_i == '0)); // R8

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_i[g] |-> !dq_oe_i[g]); // R9

    AST_WRITE_LANE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_i[g] |-> $past(lane_low_i[g])); // R2

    AST_OFF_UNTIL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_valid_i[g] && !lane_fall_i[g]) |=> !rd_valid_i[g]); // R7
  end
endmodule

bind edo_lane_ctrl edo_lane_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ras_act_i   (ras_act),
  .cas_act_i   (cas_act),
  .lane_low_i  (lane_low),
  .lane_fall_i (lane_fall),
  .rd_valid_i  (rd_valid_q),
  .dq_oe_i     (dq_oe_o),
  .wr_stb_i    (wr_stb_o),
  .cbr_stb_i   (cbr_stb_o)
);

// File: tb/edo_lane_ctrl_tb.sv
`timescale 1ns/1ps
module edo_lane_ctrl_tb;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq = '0;
  logic [15:0]   dq_o, wr_data_o;
  logic [1:0]    dq_oe_o, wr_stb_o;
  logic [2*AW-1:0] wr_addr_o;
  logic          cbr_stb_o;
  logic [AW-1:0] ref_row_o;

  int n_cmp = 0, n_err = 0;
  int wr_cnt = 0, cbr_cnt = 0;
  logic [1:0]  last_stb;
  logic [5:0]  last_addr;
  logic [15:0] last_data;

  always #10 clk = ~clk;

  edo_lane_ctrl #(.ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .casl_ni(casl_n), .cash_ni(cash_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(dq), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .cbr_stb_o(cbr_stb_o), .ref_row_o(ref_row_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o != 2'b00) begin
      wr_cnt++;
      last_stb  = wr_stb_o;
      last_addr = wr_addr_o;
      last_data = wr_data_o;
    end
    if (cbr_stb_o) cbr_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic open_row(input logic [AW-1:0] r);
    addr = r; tick(2);
    ras_n = 1'b0; tick(6);
  endtask

  task automatic strobes(input logic lo, input logic hi);
    casl_n = ~lo; cash_n = ~hi; tick(6);
  endtask

  task automatic close_row();
    casl_n = 1'b1; cash_n = 1'b1; tick(3);
    ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; tick(6);
  endtask

  task automatic start_read(input logic [AW-1:0] r, input logic [AW-1:0] c,
                            input logic lo, input logic hi);
    open_row(r);
    addr = c; we_n = 1'b1; oe_n = 1'b0; tick(2);
    strobes(lo, hi);
  endtask

  task automatic early_write(input logic [AW-1:0] r, input logic [AW-1:0] c,
                             input logic lo, input logic hi, input logic [15:0] d);
    open_row(r);
    addr = c; dq = d; we_n = 1'b0; oe_n = 1'b0; tick(2);
    strobes(lo, hi);
    check("R9 no drive in early write", dq_oe_o, 2'b00);
    close_row();
  endtask

  task automatic t_reset();
    check("R8 reset drive", dq_oe_o, 2'b00);
    check("R8 reset write pulse", wr_stb_o, 2'b00);
    check("R8 reset refresh pulse", cbr_stb_o, 1'b0);
  endtask

  task automatic t_early_word();
    int w0;
    w0 = wr_cnt;
    early_write(3'd1, 3'd2, 1'b1, 1'b1, 16'hA5C3);
    check("R12 write count", wr_cnt - w0, 1);
    check("R12 write lanes", last_stb, 2'b11);
    check("R12 write address", last_addr, 6'd10);
    check("R12 write data", last_data, 16'hA5C3);
  endtask

  task automatic t_byte_writes();
    early_write(3'd1, 3'd3, 1'b1, 1'b0, 16'hFF12);
    check("R2 lower lane pulse", last_stb, 2'b01);
    check("R12 byte address", last_addr, 6'd11);
    early_write(3'd1, 3'd3, 1'b0, 1'b1, 16'h99EE);
    check("R2 upper lane pulse", last_stb, 2'b10);
    start_read(3'd1, 3'd3, 1'b1, 1'b1);
    check("R2 byte merge readback", dq_o, 16'h9912);
    close_row();
  endtask

  task automatic t_read_word();
    start_read(3'd1, 3'd2, 1'b1, 1'b1);
    check("R3 read drive", dq_oe_o, 2'b11);
    check("R3 read data", dq_o, 16'hA5C3);
    strobes(1'b0, 1'b0);
    check("R4 edo hold drive", dq_oe_o, 2'b11);
    check("R4 edo hold data", dq_o, 16'hA5C3);
    ras_n = 1'b1; tick(6);
    check("R8 off after row close", dq_oe_o, 2'b00);
    close_row();
  endtask

  task automatic t_lane_read();
    start_read(3'd1, 3'd3, 1'b0, 1'b1);
    check("R2 upper only drive", dq_oe_o, 2'b10);
    check("R2 upper data", dq_o[15:8], 8'h99);
    close_row();
  endtask

  task automatic t_first_last();
    start_read(3'd1, 3'd2, 1'b1, 1'b0);
    check("R1 first strobe drive", dq_oe_o, 2'b01);
    strobes(1'b1, 1'b1);
    strobes(1'b0, 1'b1);
    oe_n = 1'b1; tick(8); oe_n = 1'b0; tick(6);
    check("R1 one strobe low blocks oe kill", dq_oe_o, 2'b11);
    strobes(1'b0, 1'b0);
    oe_n = 1'b1; tick(8); oe_n = 1'b0; tick(6);
    check("R1 off after last rise", dq_oe_o, 2'b00);
    close_row();
  endtask

  task automatic t_oe_at_rise();
    start_read(3'd1, 3'd2, 1'b1, 1'b1);
    oe_n = 1'b1; tick(2);
    casl_n = 1'b1; cash_n = 1'b1; tick(1);
    oe_n = 1'b0; tick(6);
    check("R5 short high keeps drive", dq_oe_o, 2'b11);
    strobes(1'b1, 1'b1);
    oe_n = 1'b1; tick(2);
    casl_n = 1'b1; cash_n = 1'b1; tick(8);
    oe_n = 1'b0; tick(6);
    check("R5 long high switches off", dq_oe_o, 2'b00);
    tick(10);
    check("R5 stays off", dq_oe_o, 2'b00);
    strobes(1'b1, 1'b1);
    check("R5 back on at strobe fall", dq_oe_o, 2'b11);
    close_row();
  endtask

  task automatic t_oe_pulse();
    start_read(3'd1, 3'd2, 1'b1, 1'b1);
    strobes(1'b0, 1'b0);
    oe_n = 1'b1; tick(1); oe_n = 1'b0; tick(6);
    check("R6 short pulse keeps drive", dq_oe_o, 2'b11);
    oe_n = 1'b1; tick(8); oe_n = 1'b0; tick(6);
    check("R6 long pulse switches off", dq_oe_o, 2'b00);
    tick(10);
    check("R6 stays off", dq_oe_o, 2'b00);
    strobes(1'b1, 1'b1);
    check("R6 back on at strobe fall", dq_oe_o, 2'b11);
    close_row();
  endtask

  task automatic t_we_off();
    start_read(3'd1, 3'd2, 1'b1, 1'b1);
    strobes(1'b0, 1'b0);
    check("R4 hold before we", dq_oe_o, 2'b11);
    we_n = 1'b0; tick(6);
    check("R7 we fall switches off", dq_oe_o, 2'b00);
    we_n = 1'b1; tick(6);
    check("R7 stays off after we high", dq_oe_o, 2'b00);
    strobes(1'b1, 1'b1);
    check("R7 read restarts", dq_oe_o, 2'b11);
    check("R7 read data", dq_o, 16'hA5C3);
    close_row();
  endtask

  task automatic t_late_write();
    int w0;
    early_write(3'd2, 3'd5, 1'b1, 1'b1, 16'h0F0F);
    start_read(3'd2, 3'd5, 1'b1, 1'b1);
    check("R3 read before late write", dq_o, 16'h0F0F);
    oe_n = 1'b1; dq = 16'hBEEF; tick(6);
    w0 = wr_cnt;
    we_n = 1'b0; tick(6);
    check("R10 late write count", wr_cnt - w0, 1);
    check("R10 late write data", last_data, 16'hBEEF);
    check("R10 late write address", last_addr, 6'd21);
    oe_n = 1'b0; tick(6);
    check("R10 lanes off after late write", dq_oe_o, 2'b00);
    close_row();
    start_read(3'd2, 3'd5, 1'b1, 1'b1);
    dq = 16'h1111; w0 = wr_cnt;
    we_n = 1'b0; tick(6);
    check("R10 oe low blocks write", wr_cnt - w0, 0);
    check("R10 oe low keeps drive", dq_oe_o, 2'b11);
    check("R10 oe low keeps data", dq_o, 16'hBEEF);
    close_row();
    start_read(3'd2, 3'd5, 1'b1, 1'b1);
    check("R10 readback", dq_o, 16'hBEEF);
    close_row();
  endtask

  task automatic t_cbr();
    int c0, w0;
    c0 = cbr_cnt; w0 = wr_cnt;
    strobes(1'b1, 1'b0);
    ras_n = 1'b0; tick(6);
    check("R11 cbr pulse", cbr_cnt - c0, 1);
    check("R11 first refresh row", ref_row_o, 3'd0);
    check("R11 no drive", dq_oe_o, 2'b00);
    close_row();
    strobes(1'b1, 1'b1);
    ras_n = 1'b0; tick(6);
    check("R11 second refresh row", ref_row_o, 3'd1);
    check("R11 no write in refresh", wr_cnt - w0, 0);
    close_row();
    c0 = cbr_cnt;
    open_row(3'd3);
    check("R11 row-only no pulse", cbr_cnt - c0, 0);
    check("R11 row-only no drive", dq_oe_o, 2'b00);
    close_row();
  endtask

  task automatic t_same_cycle();
    int w0;
    w0 = wr_cnt;
    open_row(3'd3);
    addr = 3'd1; dq = 16'h5A5A; oe_n = 1'b0; tick(2);
    we_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; tick(6);
    check("R9 same sample single write", wr_cnt - w0, 1);
    check("R9 same sample data", last_data, 16'h5A5A);
    check("R9 same sample no drive", dq_oe_o, 2'b00);
    close_row();
    start_read(3'd3, 3'd1, 1'b1, 1'b1);
    check("R9 same sample readback", dq_o, 16'h5A5A);
    close_row();
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1; tick(4);
    t_early_word();
    t_byte_writes();
    t_read_word();
    t_lane_read();
    t_first_last();
    t_oe_at_rise();
    t_oe_pulse();
    t_we_off();
    t_late_write();
    t_cbr();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule